// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples a set of general-purpose pins (32 by default) through a small register bus with address, write enable, write data and read data. Software picks each pin's direction and moves output pins high or low by writing ones to separate set and clear words. A zero bit in those writes leaves its pin alone. Input levels pass through a two-flop synchronizer before they can be read.

Each pin has its own interrupt detector. Three per-pin configuration words choose how it fires: a detection-method bit selects edge or level, a dual-edge bit makes any transition count, and a polarity bit picks rising or falling (edge mode) or high or low (level mode). An edge event sets a sticky pending flag that stays until software acknowledges it. In level mode the status bit tracks the qualified synchronized level. Every pin's status is readable in raw form and in masked form, and all masked bits are ORed onto one interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, pinOe is all zero, pinOut is all zero and irqOut is low. The direction word (0x04) reads all ones. The enable (0x10), mask (0x14), raw status (0x18), masked status (0x1C), method (0x24), dual-edge (0x28) and polarity (0x2C) words read zero.
- R2: A write to 0x04 loads the direction word, where 1 means input and 0 means output. From the next cycle pinOe is the bitwise inverse of that word.
- R3: A write to 0x08 drives high every pin whose data bit is 1. Pins with a 0 bit keep their value. Reading 0x08 returns the output latch.
- R4: A write to 0x0C drives low every pin whose data bit is 1. Pins with a 0 bit keep their value.
- R5: Reading 0x00 returns the pin inputs after a two-flop synchronizer.
- R6: With method bit 0, dual-edge bit 0 and polarity bit 0, a rising input sets the pin's sticky bit in the raw status word (0x18). A falling input does not set it, and it does not remove it.
- R7: With method 0, dual-edge 0 and polarity 1, a falling input sets the pending bit and a rising input does not.
- R8: With method 0 and dual-edge 1, both transitions set the pending bit, whatever the polarity bit.
- R9: With method bit 1, the raw bit follows the synchronized input: polarity 0 means high is active and polarity 1 means low is active. The bit drops as soon as the level goes inactive.
- R10: Writing 1 to a bit of 0x20 clears that pin's edge-pending flag. Zero bits leave their pending flags set, and an active level-mode bit stays set.
- R11: The masked status word (0x1C) equals raw AND enable AND NOT mask, and irqOut is high exactly when that word is nonzero.
- R12: The raw status word records events whatever the enable and mask settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | PIN_N | Write data |
| busRdata | output | PIN_N | Read data for busAddr (combinational) |
| pinIn | input | PIN_N | Pin input levels (asynchronous) |
| pinOut | output | PIN_N | Pin output levels |
| pinOe | output | PIN_N | Pin output enables, 1 drives the pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the ones where an edge-pending flag and a level-mode bit meet the acknowledge path. These are an acknowledge with zero bits while a flag is still pending, and an acknowledge that lands while a level source is still active. The stimulus reaches them by reconfiguring one pin at a time into each trigger mode. It toggles that pin and waits out the synchronizer delay. It then issues partial and full acknowledge writes, and reads the raw and masked words after each step. A final pass with two pending sources and a changing enable and mask pair shows that the combined line depends only on the masked word.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int OFF_LVL  = 'h00;
  localparam int OFF_DIR  = 'h04;
  localparam int OFF_SET  = 'h08;
  localparam int OFF_CLR  = 'h0C;
  localparam int OFF_EN   = 'h10;
  localparam int OFF_MASK = 'h14;
  localparam int OFF_RAW  = 'h18;
  localparam int OFF_MSK  = 'h1C;
  localparam int OFF_ACK  = 'h20;
  localparam int OFF_METH = 'h24;
  localparam int OFF_BOTH = 'h28;
  localparam int OFF_POL  = 'h2C;

  typedef struct packed {
    logic dirWr;
    logic setWr;
    logic clrWr;
    logic enWr;
    logic maskWr;
    logic ackWr;
    logic methWr;
    logic bothWr;
    logic polWr;
  } regStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_LVL, RD_DIR, RD_OUT, RD_EN, RD_MASK,
    RD_RAW, RD_MSK, RD_METH, RD_BOTH, RD_POL
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strobe        = '0;
    strobe.dirWr  = busWe && hit(busAddr, OFF_DIR);
    strobe.setWr  = busWe && hit(busAddr, OFF_SET);
    strobe.clrWr  = busWe && hit(busAddr, OFF_CLR);
    strobe.enWr   = busWe && hit(busAddr, OFF_EN);
    strobe.maskWr = busWe && hit(busAddr, OFF_MASK);
    strobe.ackWr  = busWe && hit(busAddr, OFF_ACK);
    strobe.methWr = busWe && hit(busAddr, OFF_METH);
    strobe.bothWr = busWe && hit(busAddr, OFF_BOTH);
    strobe.polWr  = busWe && hit(busAddr, OFF_POL);
  end

  always_comb begin
    rdSel = RD_NONE;
    if      (hit(busAddr, OFF_LVL))  rdSel = RD_LVL;
    else if (hit(busAddr, OFF_DIR))  rdSel = RD_DIR;
    else if (hit(busAddr, OFF_SET))  rdSel = RD_OUT;
    else if (hit(busAddr, OFF_EN))   rdSel = RD_EN;
    else if (hit(busAddr, OFF_MASK)) rdSel = RD_MASK;
    else if (hit(busAddr, OFF_RAW))  rdSel = RD_RAW;
    else if (hit(busAddr, OFF_MSK))  rdSel = RD_MSK;
    else if (hit(busAddr, OFF_METH)) rdSel = RD_METH;
    else if (hit(busAddr, OFF_BOTH)) rdSel = RD_BOTH;
    else if (hit(busAddr, OFF_POL))  rdSel = RD_POL;
  end

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic methLevel,
  input  logic dualEdge,
  input  logic polarity,
  input  logic ackBit,
  output logic rawStat
);

  logic prevLvl;
  logic edgePend;
  logic riseSeen;
  logic fallSeen;
  logic edgeHit;
  logic lvlActive;

  assign riseSeen  = lvl & ~prevLvl;
  assign fallSeen  = ~lvl & prevLvl;
  assign edgeHit   = dualEdge ? (riseSeen | fallSeen)
                              : (polarity ? fallSeen : riseSeen);
  assign lvlActive = polarity ? ~lvl : lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLvl  <= 1'b0;
      edgePend <= 1'b0;
    end else begin
      prevLvl <= lvl;
      if (!methLevel && edgeHit) edgePend <= 1'b1;
      else if (ackBit)           edgePend <= 1'b0;
    end
  end

  assign rawStat = methLevel ? lvlActive : edgePend;

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  regStrobe_t       strobe,
  input  rdSel_t           rdSel,
  input  logic [PIN_N-1:0] busWdata,
  output logic [PIN_N-1:0] busRdata,
  input  logic [PIN_N-1:0] pinIn,
  output logic [PIN_N-1:0] pinOut,
  output logic [PIN_N-1:0] pinOe,
  output logic             irqOut
);

  logic [PIN_N-1:0] dirReg, outReg, enReg, maskReg;
  logic [PIN_N-1:0] methReg, bothReg, polReg;
  logic [PIN_N-1:0] syncA, syncB;
  logic [PIN_N-1:0] rawVec, maskedVec, ackVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg  <= '1;
      outReg  <= '0;
      enReg   <= '0;
      maskReg <= '0;
      methReg <= '0;
      bothReg <= '0;
      polReg  <= '0;
    end else begin
      if (strobe.dirWr)  dirReg  <= busWdata;
      if (strobe.setWr)  outReg  <= outReg | busWdata;
      else if (strobe.clrWr) outReg <= outReg & ~busWdata;
      if (strobe.enWr)   enReg   <= busWdata;
      if (strobe.maskWr) maskReg <= busWdata;
      if (strobe.methWr) methReg <= busWdata;
      if (strobe.bothWr) bothReg <= busWdata;
      if (strobe.polWr)  polReg  <= busWdata;
    end
  end

  assign ackVec = strobe.ackWr ? busWdata : '0;

  for (genvar i = 0; i < PIN_N; i++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (syncB[i]),
      .methLevel (methReg[i]),
      .dualEdge  (bothReg[i]),
      .polarity  (polReg[i]),
      .ackBit    (ackVec[i]),
      .rawStat   (rawVec[i])
    );
  end

  assign maskedVec = rawVec & enReg & ~maskReg;
  assign irqOut    = |maskedVec;
  assign pinOut    = outReg;
  assign pinOe     = ~dirReg;

  always_comb begin
    unique case (rdSel)
      RD_LVL:  busRdata = syncB;
      RD_DIR:  busRdata = dirReg;
      RD_OUT:  busRdata = outReg;
      RD_EN:   busRdata = enReg;
      RD_MASK: busRdata = maskReg;
      RD_RAW:  busRdata = rawVec;
      RD_MSK:  busRdata = maskedVec;
      RD_METH: busRdata = methReg;
      RD_BOTH: busRdata = bothReg;
      RD_POL:  busRdata = polReg;
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PIN_N  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PIN_N-1:0]  busWdata,
  output logic [PIN_N-1:0]  busRdata,
  input  logic [PIN_N-1:0]  pinIn,
  output logic [PIN_N-1:0]  pinOut,
  output logic [PIN_N-1:0]  pinOe,
  output logic              irqOut
);

  regStrobe_t strobe;
  rdSel_t     rdSel;

  gpio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_irq_datapath #(.PIN_N(PIN_N)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int PIN_N  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [PIN_N-1:0]  busWdata,
  input logic [PIN_N-1:0]  busRdata,
  input logic [PIN_N-1:0]  pinIn,
  input logic [PIN_N-1:0]  pinOut,
  input logic [PIN_N-1:0]  pinOe,
  input logic              irqOut
);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_DIR)) |=> (pinOe == ~$past(busWdata)));

  // R3
  set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_SET)) |=>
      (((pinOut & $past(busWdata)) == $past(busWdata)) &&
       ((pinOut & ~$past(busWdata)) == ($past(pinOut) & ~$past(busWdata)))));

  // R4
  clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_CLR)) |=>
      (((pinOut & $past(busWdata)) == '0) &&
       ((pinOut & ~$past(busWdata)) == ($past(pinOut) & ~$past(busWdata)))));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_EN) && busWdata == '0) |=> !irqOut);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.PIN_N(PIN_N), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  import gpio_irq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PIN_N = 32;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [PIN_N-1:0] busWdata = '0;
  logic [PIN_N-1:0] busRdata;
  logic [PIN_N-1:0] pinIn = '0;
  logic [PIN_N-1:0] pinOut;
  logic [PIN_N-1:0] pinOe;
  logic irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.PIN_N(PIN_N), .ADDR_W(ADDR_W)) u_dut (.*);

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;
  int       checks = 0;
  int       errors = 0;
  bit       done = 0;

  // Monitor: pops each expected item and compares it with the live output
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.src)
          0: act = busRdata;
          1: act = pinOut;
          2: act = pinOe;
          default: act = {31'b0, irqOut};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int src, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    #1;
    -> sampleEv;
    #1;
  endtask

  task automatic rdChk(input int off, input logic [31:0] exp, input string tag);
    busAddr = ADDR_W'(off);
    push(0, exp, tag);
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(off); busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic setPin(input int b, input logic v);
    @(negedge clk);
    pinIn[b] = v;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    push(2, 32'h0, "R1 pinOe");
    push(1, 32'h0, "R1 pinOut");
    push(3, 32'h0, "R1 irqOut");
    rdChk(OFF_DIR, 32'hFFFF_FFFF, "R1 dir");
    rdChk(OFF_RAW, 32'h0, "R1 raw");
    rdChk(OFF_EN, 32'h0, "R1 enable");
    rdChk(OFF_POL, 32'h0, "R1 polarity");

    // R2 direction
    wr(OFF_DIR, 32'h0000_00FF);
    push(2, 32'hFFFF_FF00, "R2 pinOe");
    rdChk(OFF_DIR, 32'h0000_00FF, "R2 dir readback");

    // R3 set, R4 clear
    wr(OFF_SET, 32'h0000_F00F);
    push(1, 32'h0000_F00F, "R3 set");
    wr(OFF_SET, 32'h0000_0100);
    push(1, 32'h0000_F10F, "R3 set keeps others");
    rdChk(OFF_SET, 32'h0000_F10F, "R3 readback");
    wr(OFF_CLR, 32'h0000_000C);
    push(1, 32'h0000_F103, "R4 clear");

    // R5 synchronized level, R6 rising pending on many pins
    @(negedge clk); pinIn = 32'hA5A5_0001; settle();
    rdChk(OFF_LVL, 32'hA5A5_0001, "R5 level read");
    @(negedge clk); pinIn = '0; settle();
    rdChk(OFF_RAW, 32'hA5A5_0001, "R6 rising sticky after fall");
    wr(OFF_ACK, 32'hFFFF_FFFF);
    rdChk(OFF_RAW, 32'h0, "R10 full ack");

    // R12 raw independent of enable, R11 masking
    setPin(0, 1'b1);
    rdChk(OFF_RAW, 32'h1, "R12 raw with enable off");
    rdChk(OFF_MSK, 32'h0, "R11 masked with enable off");
    push(3, 32'h0, "R11 irq with enable off");
    setPin(0, 1'b0);
    rdChk(OFF_RAW, 32'h1, "R6 fall keeps pending");
    wr(OFF_EN, 32'h1);
    rdChk(OFF_MSK, 32'h1, "R11 masked enabled");
    push(3, 32'h1, "R11 irq enabled");
    wr(OFF_MASK, 32'h1);
    rdChk(OFF_MSK, 32'h0, "R11 masked by mask");
    push(3, 32'h0, "R11 irq masked");
    rdChk(OFF_RAW, 32'h1, "R12 raw under mask");
    wr(OFF_MASK, 32'h0);
    push(3, 32'h1, "R11 irq unmasked");

    // R10 partial ack
    wr(OFF_ACK, 32'h2);
    rdChk(OFF_RAW, 32'h1, "R10 zero bit keeps pending");
    wr(OFF_ACK, 32'h1);
    rdChk(OFF_RAW, 32'h0, "R10 ack clears");
    push(3, 32'h0, "R10 irq after ack");

    // R7 falling
    wr(OFF_POL, 32'h2);
    setPin(1, 1'b1);
    rdChk(OFF_RAW, 32'h0, "R7 rise ignored");
    setPin(1, 1'b0);
    rdChk(OFF_RAW, 32'h2, "R7 fall pending");
    wr(OFF_ACK, 32'h2);

    // R8 both edges, polarity ignored
    wr(OFF_BOTH, 32'h4);
    wr(OFF_POL, 32'h6);
    setPin(2, 1'b1);
    rdChk(OFF_RAW, 32'h4, "R8 rise pending");
    wr(OFF_ACK, 32'h4);
    rdChk(OFF_RAW, 32'h0, "R8 ack");
    setPin(2, 1'b0);
    rdChk(OFF_RAW, 32'h4, "R8 fall pending");
    wr(OFF_ACK, 32'h4);

    // R9 level modes
    wr(OFF_METH, 32'h8);
    rdChk(OFF_RAW, 32'h0, "R9 high inactive");
    setPin(3, 1'b1);
    rdChk(OFF_RAW, 32'h8, "R9 high active");
    wr(OFF_ACK, 32'h8);
    rdChk(OFF_RAW, 32'h8, "R10 ack keeps active level");
    setPin(3, 1'b0);
    rdChk(OFF_RAW, 32'h0, "R9 high drops");
    wr(OFF_POL, 32'hE);
    rdChk(OFF_RAW, 32'h8, "R9 low active");
    setPin(3, 1'b1);
    rdChk(OFF_RAW, 32'h0, "R9 low drops");

    // R11 mixed sources
    setPin(0, 1'b1);
    setPin(2, 1'b1);
    rdChk(OFF_RAW, 32'h5, "R12 two pending");
    wr(OFF_EN, 32'h4);
    wr(OFF_MASK, 32'h4);
    rdChk(OFF_MSK, 32'h0, "R11 masked bit2");
    push(3, 32'h0, "R11 irq low");
    wr(OFF_MASK, 32'h0);
    rdChk(OFF_MSK, 32'h4, "R11 enable selects bit2");
    push(3, 32'h1, "R11 irq high");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule